// File: doc/BRIEF.md
# Linked-Ring Receive DMA Channel

This block is one receive channel of a descriptor-driven DMA engine. It takes a byte stream from a serial framer and stores the bytes into packet buffers in a shared memory. The buffers are described by a ring of descriptors held in that same memory. Each descriptor is eight bytes long and names the next descriptor, its own data buffer, the number of bytes stored, and a status byte. The engine follows the chain pointers by itself. After each descriptor it loads the current pointer from the chain field, so the host never restarts it between frames.

The host programs the channel through a small register port. That port sets the current and stop descriptor offsets, the high address bits shared by all offsets, and the per-descriptor buffer size. The engine keeps running until the current descriptor equals the stop descriptor. At that point it halts, flags the event and waits. The host then moves the stop pointer forward over the descriptors it has drained, and sets the run bit again.

A frame longer than one buffer continues into the following descriptors. Only the descriptor that holds the last byte carries the end-of-frame mark and the framer's error flags. Event flags are cleared with a qualified write, and a masked OR of the flags drives one interrupt line.

Top module: `cdma_rx_channel`

## Requirements
- R1: After reset, every readable register reads 0, and `irq`, `rx_ready` and `mem_req` are low.
- R2: Every memory address is {BASE, 16-bit offset}. When the engine starts a descriptor at offset C, it reads the chain pointer from C+0 and C+1 and the buffer pointer from C+2 and C+3, both little-endian. It then stores the stream bytes at consecutive offsets from the buffer pointer. Next it writes the stored byte count to C+4 (low byte) and C+5 (high byte), writes the status byte to C+6, and sets CUR to the chain pointer.
- R3: A descriptor takes at most BUFLEN bytes, and the remaining bytes of the frame go to the next descriptor. The status byte of a non-final fragment is 0x00. The status byte of the final fragment has bit 7 set, and bits 4:0 copy `rx_err` as sampled with the last byte. The `rx_err` bits are: bit 0 overrun, bit 1 short frame, bit 2 abort, bit 3 residual bits, bit 4 CRC error. A frame of exactly BUFLEN bytes uses one descriptor.
- R4: At a descriptor boundary with the run bit set, if CUR equals STOP, the engine sets flag BOF (STAT bit 2) and flag EOT (STAT bit 1) and clears the run bit. Moving STOP and setting the run bit again resumes the engine at CUR.
- R5: Each final fragment sets flag EOM (STAT bit 0) and adds one to the frame counter FCNT. If the counter wraps from its maximum value to 0, the engine also sets flag COF (STAT bit 3).
- R6: A STAT write with bit 4 set clears each flag whose bit is written as 1 and leaves the run bit unchanged. A STAT write with bit 4 clear loads the run bit (STAT bit 7) from bit 7 and leaves the flags unchanged.
- R7: `irq` is high exactly when a flag is set and its enable in IEN (same bit positions 3:0) is set.
- R8: A CMD write with bit 0 set stops the engine at once, even in the middle of a frame. It clears the run bit and all flags and stops accepting stream bytes. A CMD write with bit 1 set zeroes FCNT.
- R9: `mem_req` stays high with stable address, direction and write data until `mem_ready`. `rx_ready` is high only while no memory access is pending.
- R10: With the run bit clear and the engine idle, no stream byte is accepted.

Register offsets on `reg_addr`: 0 CUR, 1 STOP, 2 BASE, 3 BUFLEN, 4 STAT, 5 IEN, 6 CMD (reads 0), 7 FCNT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | BASE_W+16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine accepts a stream byte |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 5 | Frame error flags, sampled with the last byte |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that closes the write cycle. The next falling edge therefore shows the new value on `reg_rdata` and `irq`. Abort and halt are checked at exactly that falling edge.

Once the last byte of a fragment has been taken, the engine needs one store and three descriptor writes, then one idle cycle, then four descriptor reads before it accepts the next byte. With half-rate memory this is about 20 cycles. The bench therefore waits a fixed 60 to 80 cycles after each frame before it reads back memory, CUR, STAT and FCNT. Stream bytes are offered only on falling edges where `rx_ready` is already high, so each byte is taken at the following rising edge.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int OFF_W  = 16;
  localparam int ERR_W  = 5;

  localparam logic [2:0] RA_CUR    = 3'd0;
  localparam logic [2:0] RA_STOP   = 3'd1;
  localparam logic [2:0] RA_BASE   = 3'd2;
  localparam logic [2:0] RA_BUFLEN = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;
  localparam logic [2:0] RA_IEN    = 3'd5;
  localparam logic [2:0] RA_CMD    = 3'd6;
  localparam logic [2:0] RA_FCNT   = 3'd7;

  localparam int FLAG_EOM = 0;
  localparam int FLAG_EOT = 1;
  localparam int FLAG_BOF = 2;
  localparam int FLAG_COF = 3;
  localparam int NFLAG    = 4;
  localparam int STAT_QUAL = 4;
  localparam int STAT_RUN  = 7;
  localparam int CMD_ABORT  = 0;
  localparam int CMD_CLRCNT = 1;

  localparam int DESC_LEN_OFS = 4;
  localparam logic [1:0] LAST_DESC_READ  = 2'd3;
  localparam logic [1:0] LAST_DESC_WRITE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_GET,
    ST_PUT,
    ST_BACK
  } eng_state_t;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [OFF_W-1:0]  reg_wdata,
  output logic [OFF_W-1:0]  reg_rdata,
  input  logic              cur_load,
  input  logic [OFF_W-1:0]  cur_next,
  input  logic              ev_eom,
  input  logic              ev_eot,
  input  logic              ev_bof,
  output logic              run,
  output logic              abort,
  output logic [OFF_W-1:0]  cur,
  output logic [OFF_W-1:0]  stop,
  output logic [BASE_W-1:0] base,
  output logic [OFF_W-1:0]  buflen,
  output logic [NFLAG-1:0]  flags,
  output logic [FCNT_W-1:0] fcnt,
  output logic              irq
);
  logic [OFF_W-1:0]  cur_q, cur_d, stop_q, buflen_q;
  logic [BASE_W-1:0] base_q;
  logic [NFLAG-1:0]  flags_q, flags_d, ien_q;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              run_q, run_d;
  logic wr_cur, wr_stop, wr_base, wr_buflen, wr_stat, wr_ien, clrcnt, cof_ev;
  logic cur_en, fcnt_en;

  always_comb begin
    wr_cur    = reg_wr && (reg_addr == RA_CUR);
    wr_stop   = reg_wr && (reg_addr == RA_STOP);
    wr_base   = reg_wr && (reg_addr == RA_BASE);
    wr_buflen = reg_wr && (reg_addr == RA_BUFLEN);
    wr_stat   = reg_wr && (reg_addr == RA_STAT);
    wr_ien    = reg_wr && (reg_addr == RA_IEN);
    abort     = reg_wr && (reg_addr == RA_CMD) && reg_wdata[CMD_ABORT];
    clrcnt    = reg_wr && (reg_addr == RA_CMD) && reg_wdata[CMD_CLRCNT];

    cur_en = wr_cur || cur_load;
    cur_d  = cur_load ? cur_next : reg_wdata;

    cof_ev  = ev_eom && !clrcnt && (fcnt_q == {FCNT_W{1'b1}});
    fcnt_en = clrcnt || ev_eom;
    fcnt_d  = clrcnt ? '0 : fcnt_q + 1'b1;

    flags_d = flags_q;
    if (abort) begin
      flags_d = '0;
    end else begin
      if (wr_stat && reg_wdata[STAT_QUAL])
        flags_d = flags_q & ~reg_wdata[NFLAG-1:0];
      flags_d[FLAG_EOM] = flags_d[FLAG_EOM] | ev_eom;
      flags_d[FLAG_EOT] = flags_d[FLAG_EOT] | ev_eot;
      flags_d[FLAG_BOF] = flags_d[FLAG_BOF] | ev_bof;
      flags_d[FLAG_COF] = flags_d[FLAG_COF] | cof_ev;
    end

    run_d = run_q;
    if (abort || ev_bof)
      run_d = 1'b0;
    else if (wr_stat && !reg_wdata[STAT_QUAL])
      run_d = reg_wdata[STAT_RUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      stop_q   <= '0;
      base_q   <= '0;
      buflen_q <= '0;
      flags_q  <= '0;
      ien_q    <= '0;
      fcnt_q   <= '0;
      run_q    <= 1'b0;
    end else begin
      if (cur_en)    cur_q    <= cur_d;
      if (wr_stop)   stop_q   <= reg_wdata;
      if (wr_base)   base_q   <= reg_wdata[BASE_W-1:0];
      if (wr_buflen) buflen_q <= reg_wdata;
      if (wr_ien)    ien_q    <= reg_wdata[NFLAG-1:0];
      if (fcnt_en)   fcnt_q   <= fcnt_d;
      flags_q <= flags_d;
      run_q   <= run_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CUR:    reg_rdata = cur_q;
      RA_STOP:   reg_rdata = stop_q;
      RA_BASE:   reg_rdata = {{(OFF_W-BASE_W){1'b0}}, base_q};
      RA_BUFLEN: reg_rdata = buflen_q;
      RA_STAT: begin
        reg_rdata[NFLAG-1:0] = flags_q;
        reg_rdata[STAT_RUN]  = run_q;
      end
      RA_IEN:    reg_rdata[NFLAG-1:0] = ien_q;
      RA_FCNT:   reg_rdata = {{(OFF_W-FCNT_W){1'b0}}, fcnt_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign run    = run_q;
  assign cur    = cur_q;
  assign stop   = stop_q;
  assign base   = base_q;
  assign buflen = buflen_q;
  assign flags  = flags_q;
  assign fcnt   = fcnt_q;
  assign irq    = |(flags_q & ien_q);
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int BASE_W = 8,
  localparam int AW = BASE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              abort,
  input  logic [OFF_W-1:0]  cur,
  input  logic [OFF_W-1:0]  stop,
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  buflen,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              cur_load,
  output logic [OFF_W-1:0]  cur_next,
  output logic              ev_eom,
  output logic              ev_eot,
  output logic              ev_bof
);
  eng_state_t       state_q, state_d;
  logic [1:0]       step_q, step_d;
  logic [OFF_W-1:0] chain_q, chain_d, bufp_q, bufp_d, cnt_q, cnt_d, cnt_inc, off;
  logic [7:0]       byte_q, byte_d;
  logic             last_q, last_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [7:0]       stat_byte;

  // memory and stream side, decoded from the present state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    off       = '0;
    mem_wdata = '0;
    rx_ready  = 1'b0;
    stat_byte = {last_q, {(7-ERR_W){1'b0}}, err_q};
    case (state_q)
      ST_DESC: begin
        mem_req = 1'b1;
        off     = cur + OFF_W'(step_q);
      end
      ST_GET: rx_ready = 1'b1;
      ST_PUT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        off       = bufp_q + cnt_q;
        mem_wdata = byte_q;
      end
      ST_BACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        off     = cur + OFF_W'(DESC_LEN_OFS) + OFF_W'(step_q);
        case (step_q)
          2'd0:    mem_wdata = cnt_q[7:0];
          2'd1:    mem_wdata = cnt_q[15:8];
          default: mem_wdata = stat_byte;
        endcase
      end
      default: ;
    endcase
    mem_addr = {base, off};
  end

  // next state
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    chain_d  = chain_q;
    bufp_d   = bufp_q;
    cnt_d    = cnt_q;
    byte_d   = byte_q;
    last_d   = last_q;
    err_d    = err_q;
    cnt_inc  = cnt_q + 1'b1;
    cur_load = 1'b0;
    cur_next = chain_q;
    ev_eom   = 1'b0;
    ev_eot   = 1'b0;
    ev_bof   = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
      step_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (run) begin
            if (cur == stop) begin
              ev_bof = 1'b1;
              ev_eot = 1'b1;
            end else begin
              state_d = ST_DESC;
              step_d  = '0;
            end
          end
        end
        ST_DESC: begin
          if (mem_ready) begin
            case (step_q)
              2'd0:    chain_d[7:0]  = mem_rdata;
              2'd1:    chain_d[15:8] = mem_rdata;
              2'd2:    bufp_d[7:0]   = mem_rdata;
              default: bufp_d[15:8]  = mem_rdata;
            endcase
            step_d = step_q + 1'b1;
            if (step_q == LAST_DESC_READ) begin
              state_d = ST_GET;
              cnt_d   = '0;
            end
          end
        end
        ST_GET: begin
          if (rx_valid) begin
            byte_d  = rx_data;
            last_d  = rx_last;
            err_d   = rx_last ? rx_err : '0;
            state_d = ST_PUT;
          end
        end
        ST_PUT: begin
          if (mem_ready) begin
            cnt_d = cnt_inc;
            if (last_q || (cnt_inc == buflen)) begin
              state_d = ST_BACK;
              step_d  = '0;
            end else begin
              state_d = ST_GET;
            end
          end
        end
        ST_BACK: begin
          if (mem_ready) begin
            if (step_q == LAST_DESC_WRITE) begin
              cur_load = 1'b1;
              ev_eom   = last_q;
              state_d  = ST_IDLE;
              step_d   = '0;
            end else begin
              step_d = step_q + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      chain_q <= '0;
      bufp_q  <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      chain_q <= chain_d;
      bufp_q  <= bufp_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/cdma_rx_channel.sv
module cdma_rx_channel
  import cdma_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int FCNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [15:0]             reg_wdata,
  output logic [15:0]             reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [BASE_W+15:0]      mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  input  logic                    mem_ready,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [7:0]              rx_data,
  input  logic                    rx_last,
  input  logic [4:0]              rx_err,
  output logic                    irq
);
  logic              rst_meta, rst_sync_n;
  logic              run, abort, cur_load, ev_eom, ev_eot, ev_bof;
  logic [OFF_W-1:0]  cur, stop, buflen, cur_next;
  logic [BASE_W-1:0] base;
  logic [NFLAG-1:0]  flags;
  logic [FCNT_W-1:0] fcnt;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cdma_regs #(.BASE_W(BASE_W), .FCNT_W(FCNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_load(cur_load), .cur_next(cur_next),
    .ev_eom(ev_eom), .ev_eot(ev_eot), .ev_bof(ev_bof),
    .run(run), .abort(abort), .cur(cur), .stop(stop), .base(base), .buflen(buflen),
    .flags(flags), .fcnt(fcnt), .irq(irq)
  );

  cdma_engine #(.BASE_W(BASE_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n),
    .run(run), .abort(abort), .cur(cur), .stop(stop), .base(base), .buflen(buflen),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err),
    .cur_load(cur_load), .cur_next(cur_next),
    .ev_eom(ev_eom), .ev_eot(ev_eot), .ev_bof(ev_bof)
  );
endmodule

// File: rtl/cdma_rx_checker.sv
module cdma_rx_checker #(
  parameter int BASE_W = 8,
  parameter int FCNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              wd_b0,
  input logic              wd_b1,
  input logic              wd_b4,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [BASE_W+15:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              rx_ready,
  input logic              run,
  input logic              flag_eom,
  input logic [FCNT_W-1:0] fcnt,
  input logic              ev_bof,
  input logic              ev_eom
);
  logic kill_now, clr_now;
  assign kill_now = reg_wr && (reg_addr == 3'd6) && wd_b0;
  assign clr_now  = reg_wr && (reg_addr == 3'd6) && wd_b1;

  // R9: a pending access keeps its request and payload
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !kill_now) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: stream accepted only with no memory access outstanding
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req);

  // R4: stop hit halts the channel
  p_bof_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bof |=> !run);

  // R8: abort leaves the engine quiet
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_now |=> (!rx_ready && !mem_req && !run));

  // R6: qualified clear of the end-of-frame flag
  p_clear_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd4) && wd_b4 && wd_b0 && !ev_eom) |=> !flag_eom);

  // R5: each final fragment advances the frame counter by one
  p_eom_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eom && !clr_now) |=> (fcnt == FCNT_W'($past(fcnt) + 1'b1)));
endmodule

bind cdma_rx_channel cdma_rx_checker #(.BASE_W(BASE_W), .FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd_b0(reg_wdata[0]), .wd_b1(reg_wdata[1]), .wd_b4(reg_wdata[4]),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rx_ready(rx_ready), .run(run), .flag_eom(flags[0]), .fcnt(fcnt),
  .ev_bof(ev_bof), .ev_eom(ev_eom)
);

// File: tb/tb_cdma_rx_channel.sv
module tb_cdma_rx_channel;
  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        rx_valid, rx_ready, rx_last;
  logic [7:0]  rx_data;
  logic [4:0]  rx_err;
  logic        irq;

  logic [7:0]  mem [0:4095];
  logic        tb_we;
  logic [11:0] tb_a;
  logic [7:0]  tb_d;
  logic        slow, phase;
  logic [7:0]  hi_seen;
  int          total, bad;

  cdma_rx_channel dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_ready = mem_req && (!slow || phase);
  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    phase <= ~phase;
    if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      hi_seen <= mem_addr[23:16];
    end
    if (tb_we) mem[tb_a] <= tb_d;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tbw(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [11:0] a, input logic [15:0] chain, input logic [15:0] bufp);
    tbw(a, chain[7:0]);     tbw(a + 12'd1, chain[15:8]);
    tbw(a + 12'd2, bufp[7:0]); tbw(a + 12'd3, bufp[15:8]);
    tbw(a + 12'd6, 8'h55);
  endtask

  task automatic push(input logic [7:0] d, input logic last, input logic [4:0] err);
    for (int n = 0; n < 2000; n++) begin
      if (rx_ready) begin
        rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
        return;
      end
      @(negedge clk);
    end
    chk("R2 stream stalled", 0, 1);
  endtask

  task automatic frame(input int n, input logic [7:0] first, input logic [4:0] err);
    for (int i = 0; i < n; i++)
      push(first + 8'(i), i == n - 1, (i == n - 1) ? err : 5'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 irq/ready/req low", {irq, rx_ready, mem_req}, 0);
  endtask

  task automatic t_single;
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0018); wr(3'd3, 16'd16);
    wr(3'd4, 16'h0080);
    frame(5, 8'hA0, 5'd0);
    idle(60);
    for (int i = 0; i < 5; i++) chk("R2 buffer byte", mem[12'h100 + 12'(i)], 8'hA0 + 8'(i));
    chk("R2 length", {mem[12'h005], mem[12'h004]}, 5);
    chk("R3 final status", mem[12'h006], 8'h80);
    rd(3'd0, v); chk("R2 cur follows chain", v, 16'h0008);
    rd(3'd4, v); chk("R5 EOM flag", v, 16'h0081);
    rd(3'd7, v); chk("R5 frame count", v, 1);
  endtask

  task automatic t_span_stop;
    logic [15:0] v;
    frame(20, 8'h10, 5'b10001);
    idle(80);
    chk("R3 first fragment byte", mem[12'h14F], 8'h1F);
    chk("R3 first fragment length", {mem[12'h00D], mem[12'h00C]}, 16);
    chk("R3 middle status", mem[12'h00E], 8'h00);
    chk("R3 tail byte", mem[12'h183], 8'h23);
    chk("R3 tail length", {mem[12'h015], mem[12'h014]}, 4);
    chk("R3 tail status with errors", mem[12'h016], 8'h91);
    rd(3'd4, v); chk("R4 BOF/EOT set and halted", v, 16'h0007);
    rd(3'd0, v); chk("R4 cur at stop", v, 16'h0018);
    chk("R4 no stream while stopped", rx_ready, 0);
  endtask

  task automatic t_flags_irq;
    logic [15:0] v;
    wr(3'd5, 16'h0001);
    chk("R7 irq on EOM", irq, 1);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk("R6 unqualified write keeps flags", v, 16'h0007);
    wr(3'd4, 16'h0011);
    rd(3'd4, v); chk("R6 qualified clear", v, 16'h0006);
    chk("R7 irq masked", irq, 0);
    wr(3'd5, 16'h0004);
    chk("R7 irq on BOF", irq, 1);
    wr(3'd4, 16'h0016);
    rd(3'd4, v); chk("R6 clear rest", v, 16'h0000);
    chk("R7 irq low", irq, 0);
    wr(3'd5, 16'h0000);
  endtask

  task automatic t_resume;
    logic [15:0] v;
    wr(3'd1, 16'h0000); wr(3'd4, 16'h0080);
    frame(3, 8'h31, 5'd0);
    idle(60);
    chk("R4 resumed buffer", mem[12'h1C2], 8'h33);
    chk("R4 resumed length", mem[12'h01C], 3);
    chk("R4 resumed status", mem[12'h01E], 8'h80);
    rd(3'd0, v); chk("R4 cur wrapped", v, 0);
    rd(3'd4, v); chk("R4 stop again", v, 16'h0007);
    wr(3'd4, 16'h001F);
  endtask

  task automatic t_exact;
    logic [15:0] v;
    tbw(12'h00E, 8'h55);
    wr(3'd1, 16'h0010); wr(3'd4, 16'h0080);
    frame(16, 8'h40, 5'd0);
    idle(60);
    chk("R3 exact length", {mem[12'h005], mem[12'h004]}, 16);
    chk("R3 exact status", mem[12'h006], 8'h80);
    chk("R3 next desc untouched", mem[12'h00E], 8'h55);
    rd(3'd4, v); chk("R5 EOM while running", v, 16'h0081);
    chk("R3 waiting on next desc", rx_ready, 1);
  endtask

  task automatic t_abort;
    logic [15:0] v;
    push(8'h01, 1'b0, 5'd0); push(8'h02, 1'b0, 5'd0);
    wr(3'd6, 16'h0001);
    chk("R8 abort refuses stream", {rx_ready, mem_req}, 0);
    rd(3'd4, v); chk("R8 abort clears", v, 0);
    rd(3'd7, v); chk("R8 counter kept by abort", v, 4);
    wr(3'd6, 16'h0002);
    rd(3'd7, v); chk("R8 counter clear", v, 0);
  endtask

  task automatic t_halted;
    logic seen;
    seen = 1'b0;
    rx_valid = 1'b1; rx_data = 8'hEE;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      seen = seen | rx_ready | mem_req;
    end
    rx_valid = 1'b0;
    chk("R10 halted ignores stream", seen, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    put_desc(12'h020, 16'h0020, 16'h0200);
    wr(3'd0, 16'h0020); wr(3'd1, 16'h0000); wr(3'd6, 16'h0002);
    wr(3'd4, 16'h0080);
    for (int i = 0; i < 16; i++) begin
      frame(1, 8'h60 + 8'(i), 5'd0);
      idle(30);
    end
    rd(3'd7, v); chk("R5 counter wrapped", v, 0);
    rd(3'd4, v); chk("R5 COF set", v, 16'h0089);
    chk("R2 self-chained buffer", mem[12'h200], 8'h6F);
    wr(3'd6, 16'h0001);
  endtask

  task automatic t_base_slow;
    logic [15:0] v;
    slow = 1'b1;
    wr(3'd2, 16'h005A);
    rd(3'd2, v); chk("R2 base readback", v, 16'h005A);
    wr(3'd4, 16'h0080);
    frame(2, 8'h77, 5'd0);
    idle(80);
    chk("R2 base on address", hi_seen, 8'h5A);
    chk("R9 slow memory data", {mem[12'h200], mem[12'h201]}, 16'h7778);
    chk("R9 slow memory length", mem[12'h024], 2);
    slow = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; rx_err = 0;
    tb_we = 0; tb_a = 0; tb_d = 0; slow = 0; phase = 0; hi_seen = 0;
    rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    t_reset;
    put_desc(12'h000, 16'h0008, 16'h0100);
    put_desc(12'h008, 16'h0010, 16'h0140);
    put_desc(12'h010, 16'h0018, 16'h0180);
    put_desc(12'h018, 16'h0000, 16'h01C0);
    t_single;
    t_span_stop;
    t_flags_irq;
    t_resume;
    t_exact;
    t_abort;
    t_halted;
    t_wrap;
    t_base_slow;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule